// File: doc/BRIEF.md
# Sync Pulse Gating Controller

This block takes one external sync input and sends it to two downstream consumers, a clock divider and a signal monitor. A single 8-bit control register decides which consumers receive it. The input is brought into the local clock domain with a two-flop synchroniser. Each rising edge that is detected becomes a strobe one clock wide on every output path that is open at that moment.

Software writes and reads the control register over a simple register bus made of an address, a write strobe, write data and combinational read data. The divider path has two modes. In continuous mode every sync edge passes through. In one-shot mode only the next sync edge passes, and the hardware then closes the divider path by clearing its enable bit.

Top module: `sync_gate_top`

## Requirements
- R1: No strobe appears on either output while control bit 0 (master enable) is low, whatever the other bits hold.
- R2: With bits 0 and 7 set, every detected rising edge of the sync input produces one strobe on the monitor output.
- R3: With bits 0 and 1 set and bit 2 clear, every detected rising edge produces one strobe on the divider output, and bit 1 stays set.
- R4: With bits 0, 1 and 2 set, only the first detected rising edge produces a divider strobe. Later edges are ignored.
- R5: When the divider strobe is issued in one-shot mode, hardware clears bit 1 in the same clock edge. A readback then shows bit 1 as 0, with bits 0, 2 and 7 unchanged.
- R6: Bits 6 to 3 always read as zero, and writing ones to them has no effect.
- R7: Each rising edge of the sync input yields a strobe exactly one clock wide, however long the input stays high. The strobe appears on the third rising clock edge after the input rises.
- R8: If a bus write to the register and the one-shot auto-clear happen at the same clock edge, bit 1 ends up 0. The other bits take the written value.
- R9: After reset the register reads 0x00, and both outputs are low.
- R10: Writes to any address other than REG_ADDR (default 0) are ignored. Reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | External sync input, asynchronous |
| busAddr | input | ADDR_W | Register address |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr |
| divSyncPulse | output | 1 | One-clock sync strobe to the clock divider |
| monSyncPulse | output | 1 | One-clock sync strobe to the signal monitor |

## Verification
A stuck or wrong gate bit shows up at the first sync edge afterwards. The symptom is a missing or extra strobe on an output, three clocks after the input rises. A failed auto-clear becomes visible only on the second edge in one-shot mode, where it lets an extra divider strobe through, and on the next register read. For that reason every one-shot case sends several edges and then reads the register back. A wrong write mask or a wrong clear priority shows up directly on the very next read.

// File: rtl/sync_gate_pkg.sv
package sync_gate_pkg;
  localparam int REG_W = 8;
  localparam int BIT_MASTER = 0;
  localparam int BIT_DIV_EN = 1;
  localparam int BIT_ONE_SHOT = 2;
  localparam int BIT_MON_EN = 7;
  localparam logic [REG_W-1:0] WRITE_MASK = 8'h87;

  typedef struct packed {
    logic master;
    logic divEn;
    logic oneShot;
    logic monEn;
  } gateCtrl_t;

  typedef struct packed {
    logic divFired;
    logic oneShotFired;
  } gateEvt_t;
endpackage

// File: rtl/sync_gate_ctrl.sv
module sync_gate_ctrl
  import sync_gate_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  gateEvt_t          evt,
  output gateCtrl_t         gate
);
  logic [REG_W-1:0] ctrlReg;
  logic [REG_W-1:0] ctrlNext;
  logic             hit;

  assign hit = (busAddr == REG_ADDR);

  always_comb begin
    ctrlNext = ctrlReg;
    if (busWr && hit) ctrlNext = busWdata & WRITE_MASK;
    if (evt.oneShotFired) ctrlNext[BIT_DIV_EN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else       ctrlReg <= ctrlNext;
  end

  assign busRdata     = hit ? ctrlReg : '0;
  assign gate.master  = ctrlReg[BIT_MASTER];
  assign gate.divEn   = ctrlReg[BIT_DIV_EN];
  assign gate.oneShot = ctrlReg[BIT_ONE_SHOT];
  assign gate.monEn   = ctrlReg[BIT_MON_EN];

  // R5 / R8: the auto-clear wins over a simultaneous write
  a_r5_autoclear: assert property (@(posedge clk) disable iff (!rstN)
    evt.oneShotFired |=> !ctrlReg[BIT_DIV_EN]);
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[6:3] == 4'b0);
  a_r10_other_addr: assert property (@(posedge clk) disable iff (!rstN)
    (!hit && !evt.oneShotFired) |=> $stable(ctrlReg));
endmodule

// File: rtl/sync_gate_dp.sv
module sync_gate_dp
  import sync_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      syncIn,
  input  gateCtrl_t gate,
  output gateEvt_t  evt,
  output logic      divSyncPulse,
  output logic      monSyncPulse
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncPrev;
  logic                   edgeDet;
  logic                   divPass;
  logic                   monPass;

  genvar i;
  generate
    for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[i] <= 1'b0;
        else if (i == 0) syncChain[i] <= syncIn;
        else syncChain[i] <= syncChain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= syncChain[SYNC_STAGES-1];
  end

  assign edgeDet = syncChain[SYNC_STAGES-1] & ~syncPrev;
  assign divPass = edgeDet & gate.master & gate.divEn;
  assign monPass = edgeDet & gate.master & gate.monEn;

  assign evt.divFired     = divPass;
  assign evt.oneShotFired = divPass & gate.oneShot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divSyncPulse <= 1'b0;
      monSyncPulse <= 1'b0;
    end else begin
      divSyncPulse <= divPass;
      monSyncPulse <= monPass;
    end
  end

  a_r1_master_gate: assert property (@(posedge clk) disable iff (!rstN)
    (divSyncPulse || monSyncPulse) |-> $past(gate.master));
  a_r7_div_single: assert property (@(posedge clk) disable iff (!rstN)
    divSyncPulse |=> !divSyncPulse);
  a_r7_mon_single: assert property (@(posedge clk) disable iff (!rstN)
    monSyncPulse |=> !monSyncPulse);
endmodule

// File: rtl/sync_gate_top.sv
module sync_gate_top
  import sync_gate_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              divSyncPulse,
  output logic              monSyncPulse
);
  gateCtrl_t gate;
  gateEvt_t  evt;

  sync_gate_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .evt(evt), .gate(gate));

  sync_gate_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .gate(gate), .evt(evt),
    .divSyncPulse(divSyncPulse), .monSyncPulse(monSyncPulse));
endmodule

// File: tb/sim_sync_gate_top.sv
module sim_sync_gate_top;
  logic clk = 0;
  logic rstN = 0;
  logic syncIn = 0;
  logic [3:0] busAddr = 0;
  logic busWr = 0;
  logic [7:0] busWdata = 0;
  logic [7:0] busRdata;
  logic divSyncPulse, monSyncPulse;
  int checks = 0, errors = 0;
  int divCnt = 0, monCnt = 0;

  always #4 clk = ~clk;

  sync_gate_top u0 (.clk(clk), .rstN(rstN), .syncIn(syncIn), .busAddr(busAddr),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .divSyncPulse(divSyncPulse), .monSyncPulse(monSyncPulse));

  always @(negedge clk) begin
    if (divSyncPulse) divCnt++;
    if (monSyncPulse) monCnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk); busWr = 0; busAddr = 0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; #1 d = busRdata; busAddr = 0;
  endtask

  task automatic syncPulses(input int n, input int hold);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); syncIn = 1;
      repeat (hold) @(negedge clk);
      syncIn = 0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic clearCounts();
    repeat (4) @(negedge clk);
    divCnt = 0; monCnt = 0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    regRead(0, d);
    check("R9 reset value", d, 8'h00);
    check("R9 div low", divSyncPulse, 0);
    check("R9 mon low", monSyncPulse, 0);
    syncPulses(1, 3);
    check("R9 no div strobe after reset", divCnt, 0);
  endtask

  task automatic testMasterOff();
    regWrite(0, 8'h86); clearCounts();
    syncPulses(2, 3);
    check("R1 div blocked", divCnt, 0);
    check("R1 mon blocked", monCnt, 0);
  endtask

  task automatic testMonitor();
    regWrite(0, 8'h81); clearCounts();
    syncPulses(3, 2);
    check("R2 mon count", monCnt, 3);
    check("R2 div count", divCnt, 0);
  endtask

  task automatic testDivCont();
    logic [7:0] d;
    regWrite(0, 8'h03); clearCounts();
    syncPulses(3, 2);
    check("R3 div count", divCnt, 3);
    check("R3 mon count", monCnt, 0);
    regRead(0, d);
    check("R3 bit1 kept", d, 8'h03);
  endtask

  task automatic testOneShot();
    logic [7:0] d;
    regWrite(0, 8'h87); clearCounts();
    syncPulses(3, 2);
    check("R4 div once", divCnt, 1);
    check("R2 mon still all", monCnt, 3);
    regRead(0, d);
    check("R5 bit1 cleared", d, 8'h85);
  endtask

  task automatic testReserved();
    logic [7:0] d;
    regWrite(0, 8'hFF);
    regRead(0, d);
    check("R6 reserved masked", d, 8'h87);
    regWrite(0, 8'h78);
    regRead(0, d);
    check("R6 reserved only", d, 8'h00);
  endtask

  task automatic testWidthLatency();
    int seen;
    regWrite(0, 8'h03); clearCounts();
    @(negedge clk); syncIn = 1;
    seen = 0;
    @(negedge clk); seen += divSyncPulse;
    @(negedge clk); seen += divSyncPulse;
    check("R7 not early", seen, 0);
    @(negedge clk);
    check("R7 strobe at third edge", divSyncPulse, 1);
    repeat (10) @(negedge clk);
    syncIn = 0;
    repeat (4) @(negedge clk);
    check("R7 one clock wide", divCnt, 1);
  endtask

  task automatic testCollision();
    logic [7:0] d;
    regWrite(0, 8'h07); clearCounts();
    @(negedge clk); syncIn = 1;
    @(negedge clk);
    @(negedge clk); busAddr = 0; busWdata = 8'h83; busWr = 1;
    @(negedge clk); busWr = 0;
    check("R8 strobe issued", divSyncPulse, 1);
    syncIn = 0;
    regRead(0, d);
    check("R8 clear wins", d, 8'h81);
  endtask

  task automatic testOtherAddr();
    logic [7:0] d;
    regWrite(0, 8'h01);
    regWrite(5, 8'h83);
    regRead(0, d);
    check("R10 write ignored", d, 8'h01);
    regRead(5, d);
    check("R10 read zero", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testMasterOff();
    testMonitor();
    testDivCont();
    testOneShot();
    testReserved();
    testWidthLatency();
    testCollision();
    testOtherAddr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule